// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Majority Vote

This block turns an asynchronous serial line into bytes. A free-running oversample strobe fires sixteen times per bit period; its interval comes from a 16-bit divisor input, so one bit lasts `16 * (divisor + 1)` clock cycles. The line first passes through a two-flop synchronizer. While the block is idle and enabled, it looks for a high-to-low transition between two consecutive strobes and treats it as the start of a frame. A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. There is no parity bit.

Within each bit, the receiver samples the line on strobe slots 7, 8 and 9, counting the slot of the detected edge as slot 0. The bit takes the value that at least two of the three samples agree on. A start bit that votes high is treated as noise and the receiver goes back to idle. At the centre of the stop bit, the assembled byte is presented for one cycle together with a framing-error flag. After a bad stop bit, the receiver waits for the line to return high. A low enable input holds the receiver idle and abandons any frame in progress.

Top module: `uart_rx_vote`

## Requirements
- R1: The oversample strobe fires once every `divisor + 1` clock cycles. One bit period spans 16 strobes, so bytes are received correctly at any divisor setting.
- R2: A frame starts only when a strobe samples the synchronized line high and the next strobe samples it low. A line that is already low when the receiver becomes ready produces no byte.
- R3: If the start bit votes high on slots 7, 8 and 9, the receiver returns to idle and emits no byte.
- R4: Each bit is the two-of-three majority of the samples on slots 7, 8 and 9. One disagreeing sample leaves the bit unchanged, and two disagreeing samples invert it.
- R5: The first data bit received lands in `byte_data[0]` and the eighth in `byte_data[7]`.
- R6: `byte_valid` rises for exactly one cycle, at slot 9 of the stop bit. `byte_data` and `frame_err` change only in that cycle and hold their values until the next byte.
- R7: A stop bit that votes low still emits the byte, with `frame_err` = 1. After that, no new frame begins until the line has been sampled high again.
- R8: While `enable` is 0 the receiver stays idle, any frame in progress is dropped, and no byte is emitted.
- R9: If the stop bit votes high while its slot-9 sample is low, the byte is emitted and that same strobe is taken as slot 0 of the next start bit.
- R10: After reset, `byte_valid`, `byte_data` and `frame_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Reception enable; low forces idle |
| divisor | input | 16 | Strobe interval minus one, in clock cycles |
| rxd | input | 1 | Asynchronous serial input, idle high |
| byte_valid | output | 1 | One-cycle pulse when a byte completes |
| byte_data | output | 8 | Last received byte |
| frame_err | output | 1 | Stop bit of the last byte voted low |

## Verification
Two functions can fall on the same strobe: emitting the completed byte and recognizing the start bit of the next frame. This happens when the next start bit arrives early enough to be the slot-9 sample of the current stop bit. The bench provokes it by shortening the stop bit to nine clock cycles and starting the next frame immediately, with a divisor of 0. It judges the result by requiring that both bytes arrive intact, in order, and with no framing error.

// File: rtl/uart_rx_vote_pkg.sv
package uart_rx_vote_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;

    // Two-of-three decision over the samples taken around the bit centre
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{chain: '1};
        else        s_q <= s_d;
    end

    assign dout = s_q.chain[STAGES-1];

endmodule

// File: rtl/rx_os_tick.sv
module rx_os_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_t;

    tick_t t_d, t_q;
    logic  wrap;

    always_comb begin
        t_d  = t_q;
        wrap = (t_q.cnt >= divisor);
        if (wrap) t_d.cnt = '0;
        else      t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{cnt: '0};
        else        t_q <= t_d;
    end

    assign tick = wrap;

    // R1: with a nonzero interval two strobes are never adjacent
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor != '0) |=> (!tick || divisor == '0));

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import uart_rx_vote_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              rx,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              frame_err
);
    localparam int SLOT_W = $clog2(OSR);
    localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [SLOT_W-1:0] SLOT_A    = SLOT_W'(OSR/2 - 1);
    localparam logic [SLOT_W-1:0] SLOT_B    = SLOT_W'(OSR/2);
    localparam logic [SLOT_W-1:0] SLOT_C    = SLOT_W'(OSR/2 + 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(OSR - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [SLOT_W-1:0] slot;
        logic [IDX_W-1:0]  idx;
        logic [1:0]        smp;
        logic [DATA_W-1:0] shreg;
        logic              prev;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              ferr;
    } eng_t;

    localparam eng_t ENG_RST = '{
        state: ST_IDLE, slot: '0, idx: '0, smp: '0, shreg: '0,
        prev: 1'b1, valid: 1'b0, data: '0, ferr: 1'b0
    };

    eng_t e_d, e_q;
    logic bit_val;

    always_comb begin
        e_d     = e_q;
        e_d.valid = 1'b0;
        bit_val = vote3(e_q.smp[0], e_q.smp[1], rx);

        if (tick) e_d.prev = rx;

        if (!enable) begin
            e_d.state = ST_IDLE;
            e_d.slot  = '0;
            e_d.idx   = '0;
        end else if (tick) begin
            unique case (e_q.state)
                ST_IDLE: begin
                    if (e_q.prev && !rx) begin
                        e_d.state = ST_START;
                        e_d.slot  = SLOT_W'(1);
                    end
                end
                ST_START, ST_DATA, ST_STOP: begin
                    e_d.slot = e_q.slot + 1'b1;
                    if (e_q.slot == SLOT_A) e_d.smp[0] = rx;
                    if (e_q.slot == SLOT_B) e_d.smp[1] = rx;
                    if (e_q.slot == SLOT_C) begin
                        if (e_q.state == ST_START) begin
                            if (bit_val) e_d.state = ST_IDLE;
                        end else if (e_q.state == ST_DATA) begin
                            e_d.shreg = {bit_val, e_q.shreg[DATA_W-1:1]};
                        end else begin
                            e_d.valid = 1'b1;
                            e_d.data  = e_q.shreg;
                            e_d.ferr  = !bit_val;
                            if (!bit_val) begin
                                e_d.state = ST_WAIT_HIGH;
                            end else if (!rx) begin
                                e_d.state = ST_START;
                                e_d.slot  = SLOT_W'(1);
                            end else begin
                                e_d.state = ST_IDLE;
                            end
                        end
                    end
                    if (e_q.slot == SLOT_LAST) begin
                        e_d.slot = '0;
                        if (e_q.state == ST_START) begin
                            e_d.state = ST_DATA;
                            e_d.idx   = '0;
                        end else if (e_q.state == ST_DATA) begin
                            if (e_q.idx == IDX_LAST) e_d.state = ST_STOP;
                            else                     e_d.idx   = e_q.idx + 1'b1;
                        end
                    end
                end
                ST_WAIT_HIGH: begin
                    if (rx) e_d.state = ST_IDLE;
                end
                default: e_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= ENG_RST;
        else        e_q <= e_d;
    end

    assign byte_valid = e_q.valid;
    assign byte_data  = e_q.data;
    assign frame_err  = e_q.ferr;

    // R6: a byte pulse never lasts two cycles
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R6: outputs only move together with the pulse
    p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |-> ($stable(byte_data) && $stable(frame_err)));

    // R8: a disabled receiver emits nothing
    p_quiet_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !byte_valid);

    // R7: a framing error parks the receiver until the line is high
    p_err_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && frame_err) |-> (e_q.state == ST_WAIT_HIGH));

    // R8: dropping enable always returns to idle
    p_idle_after_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (e_q.state == ST_IDLE));

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
    parameter int DIV_W  = 16,
    parameter int OSR    = 16,
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              rxd,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              frame_err
);
    logic rx_s;
    logic os_tick;

    rx_line_sync #(.STAGES(SYNC_N)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    rx_os_tick #(.DIV_W(DIV_W)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .divisor(divisor),
        .tick   (os_tick)
    );

    rx_frame_engine #(.OSR(OSR), .DATA_W(DATA_W)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (os_tick),
        .rx        (rx_s),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .frame_err (frame_err)
    );

endmodule

// File: tb/test_uart_rx_vote.sv
`timescale 1ns/1ps
module test_uart_rx_vote;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] divisor = 16'd0;
    logic        rxd = 1'b1;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        frame_err;

    always #2.5 clk = ~clk;

    uart_rx_vote i_uart_rx_vote (
        .clk(clk), .rst_n(rst_n), .enable(enable), .divisor(divisor),
        .rxd(rxd), .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_err(frame_err)
    );

    int checks = 0;
    int failures = 0;
    int bitclk = 16;
    string cur_tag = "R10";
    logic [8:0] exp_q[$];
    string      tag_q[$];
    bit         done = 0;

    // Scoreboard monitor
    bit         hold_chk = 0;
    logic [8:0] last_got;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_chk) begin
                hold_chk = 0;
                checks++;
                if (byte_valid || {frame_err, byte_data} != last_got) begin
                    failures++;
                    $display("FAIL R6 after pulse valid=%0b out=%h expected valid=0 out=%h",
                             byte_valid, {frame_err, byte_data}, last_got);
                end
            end else if (byte_valid) begin
                checks++;
                last_got = {frame_err, byte_data};
                hold_chk = 1;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL %s unexpected byte ferr/data=%h expected none", cur_tag, last_got);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (last_got !== e) begin
                        failures++;
                        $display("FAIL %s ferr/data=%h expected %h", t, last_got, e);
                    end
                end
            end
        end
    end

    task automatic expect_byte(input logic [7:0] b, input logic ferr, input string t);
        exp_q.push_back({ferr, b});
        tag_q.push_back(t);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Drives a frame; bit index 0 = start, 1..8 data, 9 stop.
    task automatic send_frame(input logic [7:0] b, input logic stop_lvl, input int stop_clks,
                              input int gbit, input int gstart, input int glen,
                              input int abort_bit);
        for (int i = 0; i < 10; i++) begin
            logic lvl;
            int   len;
            lvl = (i == 0) ? 1'b0 : (i == 9) ? stop_lvl : b[i-1];
            len = (i == 9) ? stop_clks : bitclk;
            for (int c = 0; c < len; c++) begin
                if (i == abort_bit && c == 0) enable = 1'b0;
                rxd = (i == gbit && c >= gstart && c < gstart + glen) ? ~lvl : lvl;
                @(negedge clk);
            end
        end
        rxd = 1'b1;
    endtask

    task automatic plain(input logic [7:0] b);
        send_frame(b, 1'b1, bitclk, -1, 0, 0, -1);
    endtask

    task automatic drained(input string t);
        idle(3 * bitclk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s missing bytes got=%0d expected 0 pending", t, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        checks++;
        if (byte_valid !== 1'b0 || byte_data !== 8'h00 || frame_err !== 1'b0) begin
            failures++;
            $display("FAIL R10 valid/data/ferr=%0b/%h/%0b expected 0/00/0",
                     byte_valid, byte_data, frame_err);
        end
        enable = 1'b1;
        idle(20);

        // R5 bit order, R1 at divisor 0
        cur_tag = "R5";
        expect_byte(8'hA5, 1'b0, "R5");  plain(8'hA5); idle(20);
        expect_byte(8'h01, 1'b0, "R5");  plain(8'h01); idle(20);
        expect_byte(8'h80, 1'b0, "R5");  plain(8'h80); idle(20);
        expect_byte(8'h3C, 1'b0, "R1");  plain(8'h3C); idle(20);
        drained("R5");

        // R4 majority: one flipped sample keeps the bit, two flip it
        cur_tag = "R4";
        expect_byte(8'h55, 1'b0, "R4");  send_frame(8'h55, 1'b1, 16, 3, 8, 1, -1); idle(20);
        expect_byte(8'h54, 1'b0, "R4");  send_frame(8'h55, 1'b1, 16, 1, 7, 2, -1); idle(20);
        expect_byte(8'h80, 1'b0, "R4");  send_frame(8'h00, 1'b1, 16, 8, 8, 2, -1); idle(20);
        expect_byte(8'hFF, 1'b0, "R4");  send_frame(8'hFF, 1'b1, 16, 5, 9, 1, -1); idle(20);
        drained("R4");

        // R3 start glitches
        cur_tag = "R3";
        rxd = 1'b0; idle(5); rxd = 1'b1; idle(60);
        rxd = 1'b0; idle(8); rxd = 1'b1; idle(60);
        drained("R3");
        expect_byte(8'h5A, 1'b0, "R3");  send_frame(8'h5A, 1'b1, 16, 0, 7, 1, -1); idle(20);
        drained("R3");

        // R7 framing error, line kept low afterwards
        cur_tag = "R7";
        expect_byte(8'hC3, 1'b1, "R7");
        send_frame(8'hC3, 1'b0, 16, -1, 0, 0, -1);
        rxd = 1'b0; idle(200); rxd = 1'b1; idle(40);
        drained("R7");
        expect_byte(8'h7E, 1'b0, "R7");  plain(8'h7E); idle(20);
        drained("R7");

        // R9 emission and next start on the same strobe
        cur_tag = "R9";
        expect_byte(8'h12, 1'b0, "R9");
        expect_byte(8'h34, 1'b0, "R9");
        send_frame(8'h12, 1'b1, 9, -1, 0, 0, -1);
        plain(8'h34); idle(20);
        drained("R9");

        // R8 disabled reception and abort mid-frame
        cur_tag = "R8";
        enable = 1'b0; plain(8'h99); idle(40);
        enable = 1'b1; idle(10);
        send_frame(8'hF0, 1'b1, 16, -1, 0, 0, 4); idle(40);
        drained("R8");
        enable = 1'b1; idle(10);
        expect_byte(8'h0F, 1'b0, "R8");  plain(8'h0F); idle(20);
        drained("R8");

        // R2 line already low when enabled
        cur_tag = "R2";
        enable = 1'b0; rxd = 1'b0; idle(50);
        enable = 1'b1; idle(100); rxd = 1'b1; idle(60);
        drained("R2");
        expect_byte(8'h66, 1'b0, "R2");  plain(8'h66); idle(20);
        drained("R2");

        // R1 divisor 2: strobe every 3 cycles, 48 cycles per bit
        cur_tag = "R1";
        divisor = 16'd2; bitclk = 48; idle(30);
        expect_byte(8'h5A, 1'b0, "R1");  plain(8'h5A); idle(60);
        expect_byte(8'hC0, 1'b0, "R1");  plain(8'hC0); idle(60);
        drained("R1");

        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 150000; k++) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired expected run to finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule